// File: doc/BRIEF.md
# Two-Wire Bus Hot-Insertion Connection Controller

This block decides when the clock and data lines of a plug-in card may be joined to a live backplane two-wire bus. It sees sampled levels of the backplane data and clock lines, the card data and clock lines, an active-high isolate request and a supply-good flag. It drives a connect enable for the external line buffer and a ready flag.

After the supply becomes good, the block waits on the backplane for one of two events. The first is a stop condition. The second is an idle period long enough to show that no transfer is in progress. It then waits for both card lines to read high, and only then joins the two buses.

A connection is broken only by an isolate request or by loss of supply. Traffic on the bus never breaks it. After isolation is released, the full wait sequence runs again before the buses are rejoined. The idle period is a parameter counted in clock cycles. At a 100 MHz clock, about 9500 cycles gives a window near 95 µs.

Top module: `hotjoin_ctrl`

## Requirements
- R1: During and right after reset, `link_en` and `ready` are low.
- R2: While `pwr_good` is low, `link_en` and `ready` are low in the same cycle and the wait sequence restarts. Bus activity during this time has no effect.
- R3: A stop condition on the backplane is a rising edge on the data line while the clock line is high, judged on synchronized samples. A stop seen after lockout counts as the join event.
- R4: The backplane counts as idle when both of its synchronized lines have been high on `IDLE_CYCLES` consecutive clocks in the waiting state. Idle is also a join event.
- R5: Any low on either backplane line restarts the idle window, so a partly elapsed window is discarded.
- R6: A join happens only while both synchronized card lines are high. An event seen while a card line is low is held until both card lines are high.
- R7: While `isolate` is high, `link_en` and `ready` are low in that same cycle. They stay low until the synchronized isolate has cleared the connection.
- R8: After `isolate` returns low, a fresh stop or idle event and high card lines are needed before `link_en` and `ready` rise again.
- R9: `ready` is high exactly when `link_en` is high, which is when supply is good, isolate is low and the start-up sequence has finished.
- R10: Once joined, the connection holds through any backplane or card line activity.
- R11: All line inputs and `isolate` pass through two-flop synchronizers. A backplane stop is therefore recognised no sooner than its third clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_good | input | 1 | Supply above its lockout level, already synchronous |
| isolate | input | 1 | Request to keep or make the buses separated |
| bp_sda | input | 1 | Backplane data line level |
| bp_scl | input | 1 | Backplane clock line level |
| card_sda | input | 1 | Card data line level |
| card_scl | input | 1 | Card clock line level |
| link_en | output | 1 | Join the card and backplane buses |
| ready | output | 1 | Card side connected and usable |

## Verification
The bench holds the backplane busy with clock toggling and a low data line, then closes with a stop. A design that mistook a start or a data change for a stop would join too early. In a separate run, low pulses are spaced just under the idle window, so a counter that failed to restart would reach idle and connect. Other runs hold a card line low after the event, pulse isolate for one cycle mid-transfer, and drop supply while joined. These catch a block that drops a pending event, lets the output glitch high again, or reconnects without a new event. A cycle-accurate reference model is compared with both outputs on every clock, so any off-by-one latency is also caught.

// File: rtl/hotjoin_ctrl.sv
module hotjoin_ctrl #(
  parameter int unsigned IDLE_CYCLES = 9500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  input  logic isolate,
  input  logic bp_sda,
  input  logic bp_scl,
  input  logic card_sda,
  input  logic card_scl,
  output logic link_en,
  output logic ready
);

  localparam int CW = $clog2(IDLE_CYCLES + 1);
  localparam logic [CW-1:0] IDLE_LAST = CW'(IDLE_CYCLES);

  typedef enum logic [1:0] {
    ST_LOCK  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_CARD  = 2'd2,
    ST_JOIN  = 2'd3
  } st_t;

  // bit order: {isolate, card_scl, card_sda, bp_scl, bp_sda}
  logic [4:0] meta_q, sync_q;
  logic       sda_prev_q;
  logic [CW-1:0] idle_cnt_q;
  st_t        st_q, st_d;

  wire bsd      = sync_q[0];
  wire bsc      = sync_q[1];
  wire card_ok  = sync_q[2] & sync_q[3];
  wire iso_s    = sync_q[4];
  wire bus_high = bsd & bsc;
  wire stop_det = bsc & bsd & ~sda_prev_q;
  wire idle_hit = (idle_cnt_q == IDLE_LAST);
  wire counting = (st_q == ST_WAIT) & pwr_good & ~iso_s & bus_high;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 5'b11111;
      sync_q     <= 5'b11111;
      sda_prev_q <= 1'b1;
    end else begin
      meta_q     <= {isolate, card_scl, card_sda, bp_scl, bp_sda};
      sync_q     <= meta_q;
      sda_prev_q <= sync_q[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      idle_cnt_q <= '0;
    else if (!counting)
      idle_cnt_q <= '0;
    else if (!idle_hit)
      idle_cnt_q <= idle_cnt_q + 1'b1;
  end

  always_comb begin
    st_d = st_q;
    if (!pwr_good)
      st_d = ST_LOCK;
    else if (iso_s)
      st_d = ST_WAIT;
    else begin
      unique case (st_q)
        ST_LOCK: st_d = ST_WAIT;
        ST_WAIT: if (stop_det || idle_hit) st_d = ST_CARD;
        ST_CARD: if (card_ok) st_d = ST_JOIN;
        ST_JOIN: st_d = ST_JOIN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_LOCK;
    else        st_q <= st_d;
  end

  assign link_en = (st_q == ST_JOIN) & pwr_good & ~(isolate | meta_q[4] | iso_s);
  assign ready   = link_en;

endmodule

// File: rtl/hotjoin_ctrl_chk.sv
module hotjoin_ctrl_chk #(
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pwr_good,
  input logic [1:0]    st,
  input logic          card_ok,
  input logic          bus_high,
  input logic          stop_det,
  input logic          idle_hit,
  input logic          iso_s,
  input logic [CW-1:0] cnt,
  input logic          link_en
);

  a_r2_lockout_on_supply_loss: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (st == 2'd0));

  a_r6_join_needs_card_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd3) && !$past(st == 2'd3) |-> $past(card_ok));

  a_r3_event_before_check: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2) && $past(st == 2'd1) |-> $past(stop_det || idle_hit));

  a_r5_window_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_high |=> (cnt == '0));

  a_r10_join_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd3) && pwr_good && !iso_s |=> (st == 2'd3));

  a_r8_no_link_outside_join: assert property (@(posedge clk) disable iff (!rst_n)
    (st != 2'd3) |-> !link_en);

endmodule

bind hotjoin_ctrl hotjoin_ctrl_chk #(.CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pwr_good (pwr_good),
  .st       (st_q),
  .card_ok  (card_ok),
  .bus_high (bus_high),
  .stop_det (stop_det),
  .idle_hit (idle_hit),
  .iso_s    (iso_s),
  .cnt      (idle_cnt_q),
  .link_en  (link_en)
);

// File: tb/hotjoin_ctrl_tb.sv
module hotjoin_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int IDLE = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_good = 1'b0, isolate = 1'b0;
  logic bp_sda = 1'b1, bp_scl = 1'b1, card_sda = 1'b1, card_scl = 1'b1;
  logic link_en, ready;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string phase = "R1";

  hotjoin_ctrl #(.IDLE_CYCLES(IDLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .isolate(isolate),
    .bp_sda(bp_sda), .bp_scl(bp_scl), .card_sda(card_sda), .card_scl(card_scl),
    .link_en(link_en), .ready(ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference: input history by age, integer phase and window count
  logic hist1 [5];
  logic hist2 [5];
  logic last_data;
  int   mode;      // 0 lockout, 1 waiting, 2 event held, 3 joined
  int   window;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 5; i++) begin hist1[i] = 1'b1; hist2[i] = 1'b1; end
      last_data = 1'b1; mode = 0; window = 0;
    end else begin
      logic d, c, cards, iso_seen, was_stop, idle_done;
      int nmode;
      d = hist2[0]; c = hist2[1]; cards = hist2[2] && hist2[3]; iso_seen = hist2[4];
      was_stop  = c && d && !last_data;
      idle_done = (window == IDLE);
      nmode = mode;
      if (!pwr_good) nmode = 0;
      else if (iso_seen) nmode = 1;
      else if (mode == 0) nmode = 1;
      else if (mode == 1 && (was_stop || idle_done)) nmode = 2;
      else if (mode == 2 && cards) nmode = 3;
      if (mode == 1 && pwr_good && !iso_seen && d && c)
        window = (window < IDLE) ? window + 1 : IDLE;
      else
        window = 0;
      mode = nmode;
      last_data = d;
      for (int i = 0; i < 5; i++) hist2[i] = hist1[i];
      hist1[0] = bp_sda; hist1[1] = bp_scl; hist1[2] = card_sda;
      hist1[3] = card_scl; hist1[4] = isolate;
    end
  end

  function automatic logic model_link();
    if (!rst_n) return 1'b0;
    return (mode == 3) && pwr_good && !isolate && !hist1[4] && !hist2[4];
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    cycles++;
    check({phase, " link_en vs model"}, link_en, model_link());
    check("R9 ready vs model", ready, model_link());
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busy_bus(input int bits);
    bp_sda = 1'b0; wait_cyc(3);
    for (int i = 0; i < bits; i++) begin
      bp_scl = 1'b0; wait_cyc(3);
      bp_scl = 1'b1; wait_cyc(3);
    end
    bp_scl = 1'b0; wait_cyc(3);
  endtask

  task automatic send_stop();
    bp_sda = 1'b0; wait_cyc(2);
    bp_scl = 1'b1; wait_cyc(3);
    bp_sda = 1'b1;
  endtask

  initial begin
    wait_cyc(3);
    #2; check("R1 reset link_en", link_en, 1'b0);
    check("R1 reset ready", ready, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    phase = "R2";
    bp_sda = 1'b0; wait_cyc(5); bp_sda = 1'b1; wait_cyc(IDLE + 10);
    #2; check("R2 lockout ignores bus", link_en, 1'b0);

    phase = "R3";
    @(negedge clk); pwr_good = 1'b1;
    busy_bus(12);
    #2; check("R3 no join while busy", link_en, 1'b0);
    send_stop();
    wait_cyc(2); #2; check("R11 stop not yet synchronized", link_en, 1'b0);
    wait_cyc(6); #2; check("R3 joined after stop", link_en, 1'b1);

    phase = "R10";
    busy_bus(8); card_sda = 1'b0; wait_cyc(4); card_sda = 1'b1;
    #2; check("R10 activity keeps link", link_en, 1'b1);
    send_stop(); wait_cyc(3);

    phase = "R7";
    busy_bus(2);
    @(negedge clk); isolate = 1'b1;
    #2; check("R7 same-cycle drop", link_en, 1'b0);
    @(negedge clk); isolate = 1'b0;
    wait_cyc(1); #2; check("R7 no regrow after pulse", ready, 1'b0);

    phase = "R8";
    wait_cyc(20); #2; check("R8 waits for new event", link_en, 1'b0);
    send_stop(); wait_cyc(10); #2; check("R8 rejoined after stop", link_en, 1'b1);

    phase = "R2";
    @(negedge clk); pwr_good = 1'b0;
    #2; check("R2 supply loss drops link", link_en, 1'b0);
    wait_cyc(3); @(negedge clk); pwr_good = 1'b1;

    phase = "R5";
    for (int k = 0; k < 6; k++) begin
      wait_cyc(IDLE - 8); bp_scl = 1'b0; @(negedge clk); bp_scl = 1'b1;
    end
    #2; check("R5 gaps short of window", link_en, 1'b0);

    phase = "R4";
    wait_cyc(IDLE - 2); #2; check("R4 before window ends", link_en, 1'b0);
    wait_cyc(12); #2; check("R4 joined after idle", link_en, 1'b1);

    phase = "R6";
    @(negedge clk); isolate = 1'b1; card_scl = 1'b0;
    wait_cyc(4); isolate = 1'b0;
    wait_cyc(IDLE + 20); #2; check("R6 held while card low", link_en, 1'b0);
    @(negedge clk); card_scl = 1'b1;
    wait_cyc(6); #2; check("R6 joined once card high", link_en, 1'b1);
    wait_cyc(5);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule